// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide programming front end of an eight-input interrupt controller. Software reaches it through two addresses, selected by one address bit (even and odd). Writes to it carry a short initialization sequence, mask updates and operation commands. The block holds the programmable state: the interrupt mask, the vector base, the lowest-priority pointer, and the mode flags. These flags are read-select, poll, special mask, auto end-of-interrupt and rotate-on-auto-EOI. The block turns each command into single-cycle strobes for the neighbouring priority resolver.

The priority resolver is a separate block. It supplies the live request and in-service vectors, and it supplies the byte returned by a poll read. It receives the strobes and the held configuration from this block. Every strobe rises on the clock edge that captures the write and lasts exactly one cycle. Read data is combinational from the address and the held state.

Top module: `irqc_cmd_port`

## Requirements
- R1: After reset the mask is 0xFF, reads of the even address return the request vector, the lowest-priority pointer is 7, the vector base is 0x00, and every mode flag is clear. The block is not in initialization.
- R2: An even-address write with bit 4 set starts initialization. It clears the mask to 0x00, sets the lowest-priority pointer to 7, and clears auto-EOI and rotate-on-auto-EOI. It pulses `init_clr_stb` for one cycle, and `in_init` goes high.
- R3: The first odd-address write during initialization loads the vector base with the written byte, its low three bits forced to zero.
- R4: Bit 0 of the starting word decides whether a fourth word follows. If it is 0, the second odd-address write ends initialization. If it is 1, a third odd-address write is expected, its bit 1 sets auto-EOI, and that write ends initialization.
- R5: An odd-address write loads the mask only outside initialization. During initialization the mask is untouched.
- R6: An even-address write with bits 4:3 = 01 is a mode command. Bits 1:0 = 10 select the request vector for even reads, and 11 select the in-service vector. Bits 6:5 = 10 clear special mask, and 11 set it. Bit 2 = 1 sets poll mode and changes nothing else.
- R7: While poll mode is set, a read at either address returns `poll_word`. That read clears poll mode and pulses `poll_ack_stb` for one cycle.
- R8: Code 0x20 pulses `eoi_ns_stb` and leaves the pointer unchanged. Code 0xA0 pulses `eoi_ns_stb` and `rot_stb` and advances the pointer by one, wrapping from 7 to 0.
- R9: Codes 0x60–0x67 pulse `eoi_spec_stb` with `eoi_lvl` equal to the code's low three bits. Codes 0xE0–0xE7 do the same and also set the pointer to that level, pulsing `prio_stb`.
- R10: Codes 0xC0–0xC7 set the pointer to the code's low three bits and pulse `prio_stb`, without any end-of-interrupt strobe.
- R11: Code 0x80 sets rotate-on-auto-EOI and 0x00 clears it. Code 0x40 changes nothing and raises no strobe.
- R12: Any other even-address code, for example 0x21 or 0x02, changes no state and pulses only `cmd_err` for one cycle.
- R13: Outside poll mode, an odd-address read returns the mask. An even-address read returns the vector chosen by the read select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr_odd | input | 1 | Address select: 0 even, 1 odd |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| req_vec | input | 8 | Request vector from priority logic |
| isr_vec | input | 8 | In-service vector from priority logic |
| poll_word | input | 8 | Byte returned by a poll read |
| mask_q | output | 8 | Interrupt mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| low_prio | output | 3 | Lowest-priority level |
| in_init | output | 1 | Initialization sequence in progress |
| auto_eoi | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi | output | 1 | Rotate on auto-EOI |
| spec_mask | output | 1 | Special mask mode |
| poll_mode | output | 1 | Next read is a poll |
| rd_isr_sel | output | 1 | Even read returns in-service vector |
| init_clr_stb | output | 1 | Clear pending state downstream |
| eoi_ns_stb | output | 1 | Non-specific end of interrupt |
| eoi_spec_stb | output | 1 | Specific end of interrupt |
| eoi_lvl | output | 3 | Level for specific end of interrupt |
| rot_stb | output | 1 | Rotate with non-specific EOI |
| prio_stb | output | 1 | Lowest-priority pointer set by command |
| poll_ack_stb | output | 1 | Poll read consumed |
| cmd_err | output | 1 | Undefined even-address code |

## Verification
The hardest state to reach is the four-word initialization. There, one odd-address write loads the base, the next is only counted, and the third sets auto-EOI. The mask must hold through all three, even though each one looks like a mask load. The bench first sets rotate-on-auto-EOI so that its clearing by the start word can be seen. It then walks the full sequence with bytes chosen so that any stray mask load, or a base without its low bits cleared, changes a visible output. The three-word path and a mask write after each path confirm where initialization ends.

// File: rtl/irqc_pkg.sv
// Shared types for the interrupt controller command port.
// Assumes an 8-level controller with byte-wide commands.
package irqc_pkg;
    localparam int unsigned LVL_W = 3;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } init_st_e;

    typedef enum logic [3:0] {
        K_BAD      = 4'd0,
        K_INIT     = 4'd1,
        K_MODE     = 4'd2,
        K_EOI_NS   = 4'd3,
        K_EOI_ROT  = 4'd4,
        K_EOI_SPEC = 4'd5,
        K_EOI_SROT = 4'd6,
        K_SET_PRIO = 4'd7,
        K_ROT_SET  = 4'd8,
        K_ROT_CLR  = 4'd9,
        K_NOP      = 4'd10
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e        kind;
        logic [LVL_W-1:0] lvl;
    } cmd_t;
endpackage

// File: rtl/irqc_cmd_decode.sv
// Classifies an even-address command byte into a command kind and level.
// Purely combinational. Assumes the caller qualifies it with an even write.
module irqc_cmd_decode
    import irqc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] code,
    output cmd_t              cmd
);
    logic low_zero;
    assign low_zero = (code[LVL_W-1:0] == '0);

    // Select command class by bit pattern: init, mode, then the 3-bit opcode table.
    always_comb begin
        cmd.lvl  = code[LVL_W-1:0];
        cmd.kind = K_BAD;
        if (code[4]) begin
            cmd.kind = K_INIT;
        end else if (code[3]) begin
            cmd.kind = K_MODE;
        end else begin
            unique case (code[7:5])
                3'b001: cmd.kind = low_zero ? K_EOI_NS  : K_BAD;
                3'b101: cmd.kind = low_zero ? K_EOI_ROT : K_BAD;
                3'b100: cmd.kind = low_zero ? K_ROT_SET : K_BAD;
                3'b000: cmd.kind = low_zero ? K_ROT_CLR : K_BAD;
                3'b010: cmd.kind = low_zero ? K_NOP     : K_BAD;
                3'b011: cmd.kind = K_EOI_SPEC;
                3'b110: cmd.kind = K_SET_PRIO;
                3'b111: cmd.kind = K_EOI_SROT;
                default: cmd.kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/irqc_init_seq.sv
// Tracks the initialization word sequence: base word, cascade word, optional mode word.
// Assumes a start word restarts the sequence from any state.
module irqc_init_seq
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic need_mode,
    input  logic odd_wr,
    output logic base_ld,
    output logic mode_ld,
    output logic in_init
);
    init_st_e st_q;
    logic     need_mode_q;

    // Advance the sequence on each odd-address write; a start word re-arms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_RUN;
            need_mode_q <= 1'b0;
        end else if (start_wr) begin
            st_q        <= ST_BASE;
            need_mode_q <= need_mode;
        end else if (odd_wr) begin
            unique case (st_q)
                ST_BASE: st_q <= ST_CASC;
                ST_CASC: st_q <= need_mode_q ? ST_MODE : ST_RUN;
                ST_MODE: st_q <= ST_RUN;
                default: st_q <= ST_RUN;
            endcase
        end
    end

    assign base_ld = odd_wr && (st_q == ST_BASE);
    assign mode_ld = odd_wr && (st_q == ST_MODE);
    assign in_init = (st_q != ST_RUN);
endmodule

// File: rtl/irqc_read_mux.sv
// Selects the read byte: poll word, mask, or request/in-service vector.
// Combinational; assumes the poll flag overrides the address.
module irqc_read_mux #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              poll_mode,
    input  logic              addr_odd,
    input  logic              rd_isr_sel,
    input  logic [DATA_W-1:0] poll_word,
    input  logic [DATA_W-1:0] mask_q,
    input  logic [DATA_W-1:0] req_vec,
    input  logic [DATA_W-1:0] isr_vec,
    output logic [DATA_W-1:0] rdata
);
    // Pick the returned byte in priority order.
    always_comb begin
        if (poll_mode)       rdata = poll_word;
        else if (addr_odd)   rdata = mask_q;
        else if (rd_isr_sel) rdata = isr_vec;
        else                 rdata = req_vec;
    end
endmodule

// File: rtl/irqc_cmd_port.sv
// Register and command front end of an 8-level interrupt controller.
// Holds programmable state and emits one-cycle strobes to the priority logic.
// Assumes wr_en and rd_en are single-cycle per access; reset is synchronous, active low.
module irqc_cmd_port
    import irqc_pkg::*;
#(
    parameter int unsigned         DATA_W     = 8,
    parameter logic [DATA_W-1:0]   MASK_RESET = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr_odd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] req_vec,
    input  logic [DATA_W-1:0] isr_vec,
    input  logic [DATA_W-1:0] poll_word,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] vec_base,
    output logic [LVL_W-1:0]  low_prio,
    output logic              in_init,
    output logic              auto_eoi,
    output logic              rot_aeoi,
    output logic              spec_mask,
    output logic              poll_mode,
    output logic              rd_isr_sel,
    output logic              init_clr_stb,
    output logic              eoi_ns_stb,
    output logic              eoi_spec_stb,
    output logic [LVL_W-1:0]  eoi_lvl,
    output logic              rot_stb,
    output logic              prio_stb,
    output logic              poll_ack_stb,
    output logic              cmd_err
);
    localparam logic [LVL_W-1:0] TOP_LVL = '1;

    cmd_t cmd;
    logic even_wr, odd_wr, base_ld, mode_ld;

    assign even_wr = wr_en && !addr_odd;
    assign odd_wr  = wr_en &&  addr_odd;

    irqc_cmd_decode #(.DATA_W(DATA_W)) u_dec (
        .code (wdata),
        .cmd  (cmd)
    );

    irqc_init_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (even_wr && (cmd.kind == K_INIT)),
        .need_mode (wdata[0]),
        .odd_wr    (odd_wr),
        .base_ld   (base_ld),
        .mode_ld   (mode_ld),
        .in_init   (in_init)
    );

    irqc_read_mux #(.DATA_W(DATA_W)) u_rd (
        .poll_mode  (poll_mode),
        .addr_odd   (addr_odd),
        .rd_isr_sel (rd_isr_sel),
        .poll_word  (poll_word),
        .mask_q     (mask_q),
        .req_vec    (req_vec),
        .isr_vec    (isr_vec),
        .rdata      (rdata)
    );

    // Hold configuration and raise one-cycle strobes for each accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q       <= MASK_RESET;
            vec_base     <= '0;
            low_prio     <= TOP_LVL;
            auto_eoi     <= 1'b0;
            rot_aeoi     <= 1'b0;
            spec_mask    <= 1'b0;
            poll_mode    <= 1'b0;
            rd_isr_sel   <= 1'b0;
            init_clr_stb <= 1'b0;
            eoi_ns_stb   <= 1'b0;
            eoi_spec_stb <= 1'b0;
            eoi_lvl      <= '0;
            rot_stb      <= 1'b0;
            prio_stb     <= 1'b0;
            poll_ack_stb <= 1'b0;
            cmd_err      <= 1'b0;
        end else begin
            init_clr_stb <= 1'b0;
            eoi_ns_stb   <= 1'b0;
            eoi_spec_stb <= 1'b0;
            rot_stb      <= 1'b0;
            prio_stb     <= 1'b0;
            poll_ack_stb <= 1'b0;
            cmd_err      <= 1'b0;

            if (rd_en && poll_mode) begin
                poll_mode    <= 1'b0;
                poll_ack_stb <= 1'b1;
            end

            if (odd_wr) begin
                if (base_ld)       vec_base <= {wdata[DATA_W-1:LVL_W], {LVL_W{1'b0}}};
                else if (mode_ld)  auto_eoi <= wdata[1];
                else if (!in_init) mask_q   <= wdata;
            end

            if (even_wr) begin
                unique case (cmd.kind)
                    K_INIT: begin
                        mask_q       <= '0;
                        low_prio     <= TOP_LVL;
                        auto_eoi     <= 1'b0;
                        rot_aeoi     <= 1'b0;
                        init_clr_stb <= 1'b1;
                    end
                    K_MODE: begin
                        if (wdata[2]) begin
                            poll_mode <= 1'b1;
                        end else begin
                            if (wdata[1:0] == 2'b10) rd_isr_sel <= 1'b0;
                            if (wdata[1:0] == 2'b11) rd_isr_sel <= 1'b1;
                            if (wdata[6:5] == 2'b10) spec_mask  <= 1'b0;
                            if (wdata[6:5] == 2'b11) spec_mask  <= 1'b1;
                        end
                    end
                    K_EOI_NS:  eoi_ns_stb <= 1'b1;
                    K_EOI_ROT: begin
                        eoi_ns_stb <= 1'b1;
                        rot_stb    <= 1'b1;
                        low_prio   <= low_prio + 1'b1;
                    end
                    K_EOI_SPEC: begin
                        eoi_spec_stb <= 1'b1;
                        eoi_lvl      <= cmd.lvl;
                    end
                    K_EOI_SROT: begin
                        eoi_spec_stb <= 1'b1;
                        eoi_lvl      <= cmd.lvl;
                        low_prio     <= cmd.lvl;
                        prio_stb     <= 1'b1;
                    end
                    K_SET_PRIO: begin
                        low_prio <= cmd.lvl;
                        prio_stb <= 1'b1;
                    end
                    K_ROT_SET: rot_aeoi <= 1'b1;
                    K_ROT_CLR: rot_aeoi <= 1'b0;
                    K_NOP:     ;
                    default:   cmd_err <= 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/irqc_cmd_port_chk.sv
// Property checker for irqc_cmd_port, bound to every instance.
// Assumes only the top-level ports and outputs are visible.
module irqc_cmd_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr_odd,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] mask_q,
    input logic [2:0] low_prio,
    input logic       in_init,
    input logic       poll_mode,
    input logic       init_clr_stb,
    input logic       eoi_ns_stb,
    input logic       eoi_spec_stb,
    input logic       poll_ack_stb,
    input logic       cmd_err
);
    p_init_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_odd && wdata[4]) |=>
        (init_clr_stb && mask_q == 8'h00 && low_prio == 3'd7 && in_init));

    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_odd && !in_init) |=> (mask_q == $past(wdata)));

    p_poll_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && poll_mode && !wr_en) |=> (poll_ack_stb && !poll_mode));

    p_err_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(wr_en && !addr_odd));

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_clr_stb, eoi_ns_stb, eoi_spec_stb, cmd_err}));

    p_odd_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr_odd && !poll_mode) |-> (rdata == mask_q));
endmodule

bind irqc_cmd_port irqc_cmd_port_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr_odd     (addr_odd),
    .wdata        (wdata),
    .rdata        (rdata),
    .mask_q       (mask_q),
    .low_prio     (low_prio),
    .in_init      (in_init),
    .poll_mode    (poll_mode),
    .init_clr_stb (init_clr_stb),
    .eoi_ns_stb   (eoi_ns_stb),
    .eoi_spec_stb (eoi_spec_stb),
    .poll_ack_stb (poll_ack_stb),
    .cmd_err      (cmd_err)
);

// File: tb/test_irqc_cmd_port.sv
// Directed bench for irqc_cmd_port: one task per scenario, each checking its own results.
module test_irqc_cmd_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr_odd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] req_vec = 8'h5A, isr_vec = 8'hA5, poll_word = 8'h83;
    logic [7:0] rdata, mask_q, vec_base;
    logic [2:0] low_prio, eoi_lvl;
    logic in_init, auto_eoi, rot_aeoi, spec_mask, poll_mode, rd_isr_sel;
    logic init_clr_stb, eoi_ns_stb, eoi_spec_stb, rot_stb, prio_stb, poll_ack_stb, cmd_err;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irqc_cmd_port i_irqc_cmd_port (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(bit odd, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr_odd = odd; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read: returns rdata sampled mid-cycle; strobes visible after the task returns.
    task automatic rd(bit odd, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr_odd = odd;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 mask", mask_q, 8'hFF);
        chk("R1 low_prio", {5'd0, low_prio}, 8'd7);
        chk("R1 base", vec_base, 8'h00);
        chk("R1 flags", {2'b0, in_init, auto_eoi, rot_aeoi, spec_mask, poll_mode, rd_isr_sel}, 8'h00);
        rd(1'b0, d);
        chk("R1 even read", d, 8'h5A);
    endtask

    task automatic t_reads;
        logic [7:0] d;
        wr(1'b0, 8'h0B);
        rd(1'b0, d);
        chk("R6/R13 isr read", d, 8'hA5);
        wr(1'b0, 8'h0A);
        rd(1'b0, d);
        chk("R6/R13 irr read", d, 8'h5A);
        rd(1'b1, d);
        chk("R13 mask read", d, 8'hFF);
    endtask

    task automatic t_init3;
        wr(1'b0, 8'h10);
        chk("R2 init_clr", {7'd0, init_clr_stb}, 8'd1);
        chk("R2 mask clr", mask_q, 8'h00);
        chk("R2 in_init", {7'd0, in_init}, 8'd1);
        wr(1'b1, 8'h45);
        chk("R3 base", vec_base, 8'h40);
        chk("R5 mask held", mask_q, 8'h00);
        wr(1'b1, 8'h04);
        chk("R4 ends after third", {7'd0, in_init}, 8'd0);
        wr(1'b1, 8'h3C);
        chk("R5 mask load", mask_q, 8'h3C);
    endtask

    task automatic t_init4;
        wr(1'b0, 8'h80);
        chk("R11 rot set", {7'd0, rot_aeoi}, 8'd1);
        wr(1'b0, 8'hC3);
        wr(1'b0, 8'h11);
        chk("R2 rot clr", {7'd0, rot_aeoi}, 8'd0);
        chk("R2 low_prio 7", {5'd0, low_prio}, 8'd7);
        wr(1'b1, 8'h77);
        chk("R3 base 70", vec_base, 8'h70);
        wr(1'b1, 8'h04);
        chk("R4 still in init", {7'd0, in_init}, 8'd1);
        chk("R5 mask held", mask_q, 8'h00);
        wr(1'b1, 8'h03);
        chk("R4 auto_eoi", {7'd0, auto_eoi}, 8'd1);
        chk("R4 init done", {7'd0, in_init}, 8'd0);
        chk("R5 mask not loaded", mask_q, 8'h00);
        wr(1'b1, 8'h81);
        chk("R5 mask after", mask_q, 8'h81);
    endtask

    task automatic t_mode_poll;
        logic [7:0] d;
        wr(1'b0, 8'h68);
        chk("R6 smm set", {7'd0, spec_mask}, 8'd1);
        wr(1'b0, 8'h48);
        chk("R6 smm clr", {7'd0, spec_mask}, 8'd0);
        wr(1'b0, 8'h6F);
        chk("R6 poll only", {6'd0, spec_mask, poll_mode}, 8'd1);
        rd(1'b1, d);
        chk("R7 poll data", d, 8'h83);
        chk("R7 poll ack", {7'd0, poll_ack_stb}, 8'd1);
        chk("R7 poll clr", {7'd0, poll_mode}, 8'd0);
    endtask

    task automatic t_eoi;
        wr(1'b0, 8'h20);
        chk("R8 ns eoi", {6'd0, eoi_ns_stb, rot_stb}, 8'd2);
        chk("R8 prio kept", {5'd0, low_prio}, 8'd7);
        wr(1'b0, 8'hA0);
        chk("R8 rot eoi", {6'd0, eoi_ns_stb, rot_stb}, 8'd3);
        chk("R8 wrap", {5'd0, low_prio}, 8'd0);
        wr(1'b0, 8'hA0);
        chk("R8 advance", {5'd0, low_prio}, 8'd1);
        wr(1'b0, 8'h63);
        chk("R9 spec", {4'd0, eoi_spec_stb, eoi_lvl}, 8'h0B);
        chk("R9 prio kept", {5'd0, low_prio}, 8'd1);
        wr(1'b0, 8'hE5);
        chk("R9 spec rot", {3'd0, prio_stb, eoi_spec_stb, eoi_lvl}, 8'h1D);
        chk("R9 prio set", {5'd0, low_prio}, 8'd5);
        wr(1'b0, 8'hC2);
        chk("R10 set prio", {4'd0, prio_stb, low_prio}, 8'h0A);
        chk("R10 no eoi", {6'd0, eoi_ns_stb, eoi_spec_stb}, 8'd0);
    endtask

    task automatic t_misc;
        wr(1'b0, 8'h00);
        chk("R11 rot clr", {7'd0, rot_aeoi}, 8'd0);
        wr(1'b0, 8'h40);
        chk("R11 nop strobes", {cmd_err, init_clr_stb, eoi_ns_stb, eoi_spec_stb, rot_stb, prio_stb, 2'b0}, 8'd0);
        chk("R11 nop prio", {5'd0, low_prio}, 8'd2);
        wr(1'b0, 8'h21);
        chk("R12 err", {7'd0, cmd_err}, 8'd1);
        chk("R12 no eoi", {7'd0, eoi_ns_stb}, 8'd0);
        @(negedge clk);
        chk("R12 one cycle", {7'd0, cmd_err}, 8'd0);
        wr(1'b0, 8'h02);
        chk("R12 err 02", {7'd0, cmd_err}, 8'd1);
        chk("R12 state kept", mask_q, 8'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads();
        t_init3();
        t_init4();
        t_mode_poll();
        t_eoi();
        t_misc();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule